// File: doc/BRIEF.md
# Programmable Chunk Packer and Unpacker for Serial Words

This block sits between a 32-bit wide FIFO and a serial protocol engine. It converts FIFO entries into protocol words and protocol words back into FIFO entries. Nothing about the packing is fixed. Up to four programmed extraction vectors decide how the bits move. Each vector names a start bit, a direction and a chunk length of one to eight bits. A stop flag on a vector marks the end of an entry. A separate word-size setting tells the block when one protocol word is complete.

The transmit side takes entries on a valid/ready input and emits words on a valid/ready output. On each vector it pulls one chunk out of the held entry and appends it to the word being built. The receive side works in the opposite direction. It takes words and deposits their bits, one chunk per vector, into the entry being built, and emits that entry once its last vector has run. Both sides read the same two configuration inputs and the same word size. Each side handles one vector per clock, and each one stalls under backpressure without losing or repeating data.

Top module: `vecpack_core`

## Requirements
- R1: Vector k (k = 0..3) is taken from `{cfg_hi, cfg_lo}` at bits [10k+9:10k]. Inside a vector, bits [9:5] are the start bit, bit 4 is the direction, bits [3:1] are the length minus one, and bit 0 is the stop flag.
- R2: A vector moves exactly length+1 bits. With direction 1 the chunk runs downward from the start bit, and the start bit is the chunk's most significant bit. With direction 0 the chunk runs upward from the start bit, and the start bit is its least significant bit. Bit positions wrap modulo 32.
- R3: On the transmit side, a direction-1 chunk is shifted into the word from the right, below the bits already collected. A direction-0 chunk is placed just above the bits already collected. A word is emitted once the number of collected bits reaches `wsize_m1`+1. Output bits at or above the word size are 0.
- R4: The vector with its stop flag set is the last vector used for an entry. The vectors after it have no effect, and vector processing then restarts at vector 0 with the next entry.
- R5: When no vector up to vector 3 has its stop flag set, vector 3 ends the entry.
- R6: A partially built transmit word carries over into the next entry. A receive word that is only partly consumed carries over into the next entry.
- R7: While `tx_wrd_valid` is high and `tx_wrd_ready` is low, the output word stays valid and unchanged. Every word is delivered exactly once.
- R8: On the receive side, a direction-1 vector takes the top length+1 bits of the word bits not yet used. A direction-0 vector takes the lowest unused bits. The chunk is written to the entry positions given by R2. Entry bits that no vector writes are 0.
- R9: On the receive side, word bits at or above the word size do not reach the entry when the vectors cover exactly the word size.
- R10: `rx_wrd_ready` rises only in the cycle that consumes the last bit of the presented word. While `rx_ent_valid` is high and `rx_ent_ready` is low, the entry stays unchanged.
- R11: After reset both outputs are not valid and `tx_ent_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lo | input | 20 | Vectors 0 (bits 9:0) and 1 (bits 19:10) |
| cfg_hi | input | 20 | Vectors 2 (bits 9:0) and 3 (bits 19:10) |
| wsize_m1 | input | 5 | Protocol word size minus one |
| tx_ent_valid | input | 1 | Transmit entry offered |
| tx_ent_ready | output | 1 | Transmit entry accepted |
| tx_ent_data | input | 32 | Transmit entry |
| tx_wrd_valid | output | 1 | Transmit word available |
| tx_wrd_ready | input | 1 | Transmit word taken |
| tx_wrd_data | output | 32 | Transmit word, right aligned |
| rx_wrd_valid | input | 1 | Receive word offered |
| rx_wrd_ready | output | 1 | Receive word fully consumed |
| rx_wrd_data | input | 32 | Receive word, right aligned |
| rx_ent_valid | output | 1 | Receive entry available |
| rx_ent_ready | input | 1 | Receive entry taken |
| rx_ent_data | output | 32 | Receive entry |

## Verification
A wrong vector index or bit counter has a visible effect at the ports. It shows up as a misaligned or shifted word on the very next emitted word. It also shifts every word after that, because the collected bit count is carried forward across entries. A stop flag that is missed makes the block produce extra words or extra entries, and those appear as soon as the stream goes idle. A dropped or repeated handshake breaks the ordered comparison of the word stream at the next transfer.

// File: rtl/vecpack_core.sv
`timescale 1ns/1ps
module vecpack_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] cfg_lo,
  input  logic [19:0] cfg_hi,
  input  logic [4:0]  wsize_m1,
  input  logic        tx_ent_valid,
  output logic        tx_ent_ready,
  input  logic [31:0] tx_ent_data,
  output logic        tx_wrd_valid,
  input  logic        tx_wrd_ready,
  output logic [31:0] tx_wrd_data,
  input  logic        rx_wrd_valid,
  output logic        rx_wrd_ready,
  input  logic [31:0] rx_wrd_data,
  output logic        rx_ent_valid,
  input  logic        rx_ent_ready,
  output logic [31:0] rx_ent_data
);
  localparam int VW = 10;
  localparam int NV = 4;

  logic [NV*VW-1:0] vecs;
  logic [5:0]       wsz;
  logic [31:0]      wmask;
  assign vecs  = {cfg_hi, cfg_lo};
  assign wsz   = {1'b0, wsize_m1} + 6'd1;
  assign wmask = 32'hFFFF_FFFF >> (5'd31 - wsize_m1);

  // transmit: entry -> words
  logic        t_full, t_ov;
  logic [1:0]  t_vi;
  logic [31:0] t_ent, t_acc, t_out;
  logic [5:0]  t_cnt;
  logic [VW-1:0] t_v;
  logic [2:0]  t_lm1;
  logic [3:0]  t_n;
  logic [4:0]  t_sh;
  logic [63:0] t_dbl;
  logic [7:0]  t_chunk;
  logic [39:0] t_up;
  logic [31:0] t_nacc;
  logic [6:0]  t_sum;
  logic        t_wdone, t_last, t_step;

  assign t_v     = vecs[t_vi*VW +: VW];
  assign t_lm1   = t_v[3:1];
  assign t_n     = {1'b0, t_lm1} + 4'd1;
  assign t_sh    = t_v[4] ? t_v[9:5] - {2'b0, t_lm1} : t_v[9:5];
  assign t_dbl   = {t_ent, t_ent} >> t_sh;
  assign t_chunk = t_dbl[7:0] & (8'hFF >> (3'd7 - t_lm1));
  assign t_up    = {8'b0, t_acc} | ({32'b0, t_chunk} << t_cnt);
  assign t_nacc  = t_v[4] ? ((t_acc << t_n) | {24'b0, t_chunk}) : t_up[31:0];
  assign t_sum   = {1'b0, t_cnt} + {3'b0, t_n};
  assign t_wdone = t_sum >= {1'b0, wsz};
  assign t_last  = t_v[0] | (t_vi == 2'd3);
  assign t_step  = t_full & (!t_wdone | !t_ov | tx_wrd_ready);

  assign tx_ent_ready = !t_full | (t_step & t_last);
  assign tx_wrd_valid = t_ov;
  assign tx_wrd_data  = t_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_full <= 1'b0;
      t_ov   <= 1'b0;
      t_vi   <= 2'd0;
      t_ent  <= '0;
      t_acc  <= '0;
      t_out  <= '0;
      t_cnt  <= '0;
    end else begin
      if (t_ov && tx_wrd_ready) t_ov <= 1'b0;
      if (t_step) begin
        if (t_wdone) begin
          t_out <= t_nacc & wmask;
          t_ov  <= 1'b1;
          t_acc <= '0;
          t_cnt <= '0;
        end else begin
          t_acc <= t_nacc;
          t_cnt <= t_sum[5:0];
        end
        if (t_last) begin
          t_vi   <= 2'd0;
          t_full <= 1'b0;
        end else begin
          t_vi <= t_vi + 2'd1;
        end
      end
      if (tx_ent_valid && tx_ent_ready) begin
        t_ent  <= tx_ent_data;
        t_full <= 1'b1;
      end
    end
  end

  // receive: words -> entry
  logic        r_ov;
  logic [1:0]  r_vi;
  logic [31:0] r_ent, r_out;
  logic [5:0]  r_used, r_rem, r_wsh;
  logic [VW-1:0] r_v;
  logic [2:0]  r_lm1;
  logic [3:0]  r_n;
  logic [4:0]  r_sh;
  logic [31:0] r_wshift;
  logic [7:0]  r_chunk;
  logic [63:0] r_pl64;
  logic [31:0] r_place;
  logic [6:0]  r_sum;
  logic        r_wdone, r_last, r_step;

  assign r_v      = vecs[r_vi*VW +: VW];
  assign r_lm1    = r_v[3:1];
  assign r_n      = {1'b0, r_lm1} + 4'd1;
  assign r_sh     = r_v[4] ? r_v[9:5] - {2'b0, r_lm1} : r_v[9:5];
  assign r_rem    = wsz - r_used;
  assign r_wsh    = r_v[4] ? ((r_rem >= {2'b0, r_n}) ? r_rem - {2'b0, r_n} : 6'd0) : r_used;
  assign r_wshift = rx_wrd_data >> r_wsh;
  assign r_chunk  = r_wshift[7:0] & (8'hFF >> (3'd7 - r_lm1));
  assign r_pl64   = {56'b0, r_chunk} << r_sh;
  assign r_place  = r_pl64[31:0] | r_pl64[63:32];
  assign r_sum    = {1'b0, r_used} + {3'b0, r_n};
  assign r_wdone  = r_sum >= {1'b0, wsz};
  assign r_last   = r_v[0] | (r_vi == 2'd3);
  assign r_step   = rx_wrd_valid & (!r_last | !r_ov | rx_ent_ready);

  assign rx_wrd_ready = r_step & r_wdone;
  assign rx_ent_valid = r_ov;
  assign rx_ent_data  = r_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_ov   <= 1'b0;
      r_vi   <= 2'd0;
      r_ent  <= '0;
      r_out  <= '0;
      r_used <= '0;
    end else begin
      if (r_ov && rx_ent_ready) r_ov <= 1'b0;
      if (r_step) begin
        r_used <= r_wdone ? 6'd0 : r_sum[5:0];
        if (r_last) begin
          r_out <= r_ent | r_place;
          r_ov  <= 1'b1;
          r_ent <= '0;
          r_vi  <= 2'd0;
        end else begin
          r_ent <= r_ent | r_place;
          r_vi  <= r_vi + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/vecpack_core_chk.sv
`timescale 1ns/1ps
module vecpack_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  wsize_m1,
  input logic        tx_wrd_valid,
  input logic        tx_wrd_ready,
  input logic [31:0] tx_wrd_data,
  input logic        rx_wrd_valid,
  input logic        rx_wrd_ready,
  input logic        rx_ent_valid,
  input logic        rx_ent_ready,
  input logic [31:0] rx_ent_data
);
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wrd_valid && !tx_wrd_ready |=> tx_wrd_valid && $stable(tx_wrd_data));

  a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ent_valid && !rx_ent_ready |=> rx_ent_valid && $stable(rx_ent_data));

  a_r10_rx_ready_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wrd_ready |-> rx_wrd_valid);

  a_r3_tx_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_wrd_valid) && $stable(wsize_m1) |->
      (tx_wrd_data & ~(32'hFFFF_FFFF >> (5'd31 - wsize_m1))) == 32'd0);

  a_r11_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !tx_wrd_valid && !rx_ent_valid);
endmodule

bind vecpack_core vecpack_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wsize_m1(wsize_m1),
  .tx_wrd_valid(tx_wrd_valid), .tx_wrd_ready(tx_wrd_ready), .tx_wrd_data(tx_wrd_data),
  .rx_wrd_valid(rx_wrd_valid), .rx_wrd_ready(rx_wrd_ready),
  .rx_ent_valid(rx_ent_valid), .rx_ent_ready(rx_ent_ready), .rx_ent_data(rx_ent_data)
);

// File: tb/vecpack_core_tb_top.sv
`timescale 1ns/1ps
module vecpack_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] cfg_lo = '0, cfg_hi = '0;
  logic [4:0]  wsize_m1 = '0;
  logic tx_ent_valid = 1'b0, tx_wrd_ready = 1'b0, rx_wrd_valid = 1'b0, rx_ent_ready = 1'b0;
  logic [31:0] tx_ent_data = '0, rx_wrd_data = '0;
  logic tx_ent_ready, tx_wrd_valid, rx_wrd_ready, rx_ent_valid;
  logic [31:0] tx_wrd_data, rx_ent_data;

  int total = 0;
  int bad = 0;
  logic [31:0] src [0:63];
  logic [31:0] expv [0:63];
  int n_src, n_exp;

  always #2.5 clk = ~clk;

  vecpack_core dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .wsize_m1(wsize_m1),
    .tx_ent_valid(tx_ent_valid), .tx_ent_ready(tx_ent_ready), .tx_ent_data(tx_ent_data),
    .tx_wrd_valid(tx_wrd_valid), .tx_wrd_ready(tx_wrd_ready), .tx_wrd_data(tx_wrd_data),
    .rx_wrd_valid(rx_wrd_valid), .rx_wrd_ready(rx_wrd_ready), .rx_wrd_data(rx_wrd_data),
    .rx_ent_valid(rx_ent_valid), .rx_ent_ready(rx_ent_ready), .rx_ent_data(rx_ent_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(int w);
    logic [63:0] m;
    m = (64'd1 << w) - 64'd1;
    return m[31:0];
  endfunction

  function automatic logic [39:0] layout(int w, int p, bit msb, bit stop_en);
    logic [9:0] v [4];
    int c8, iter, istart, idx, tmp, len;
    for (int k = 0; k < 4; k++) v[k] = '0;
    c8 = ((w + 7) / 8) * 8;
    iter = c8 * p / 8;
    istart = msb ? w - 1 : 0;
    idx = istart;
    tmp = w;
    for (int i = 0; i < iter; i++) begin
      len = ((tmp < 8) ? tmp : 8) - 1;
      v[i] = {5'(idx), msb, 3'(len), 1'b0};
      if (tmp <= 8) begin
        idx = (i + 1) * 8 + istart;
        tmp = w;
      end else begin
        idx = msb ? idx - 8 : idx + 8;
        tmp = tmp - 8;
      end
    end
    if (stop_en) v[iter-1][0] = 1'b1;
    return {v[3], v[2], v[1], v[0]};
  endfunction

  task automatic tx_run(string tag);
    fork
      begin
        for (int i = 0; i < n_src; i++) begin
          bit ok;
          tx_ent_valid = 1'b1;
          tx_ent_data = src[i];
          ok = 1'b0;
          while (!ok) begin
            #2;
            ok = tx_ent_ready;
            @(negedge clk);
          end
          tx_ent_valid = 1'b0;
          if ($urandom % 4 == 0) @(negedge clk);
        end
      end
      begin
        for (int j = 0; j < n_exp; j++) begin
          bit got;
          got = 1'b0;
          while (!got) begin
            tx_wrd_ready = ($urandom % 3) != 0;
            #2;
            if (tx_wrd_valid && tx_wrd_ready) begin
              chk(tag, tx_wrd_data, expv[j]);
              got = 1'b1;
            end
            @(negedge clk);
          end
        end
        tx_wrd_ready = 1'b0;
      end
    join
    repeat (6) @(negedge clk);
    chk({tag, " R7 no extra word"}, {31'b0, tx_wrd_valid}, 32'd0);
  endtask

  task automatic rx_run(string tag);
    fork
      begin
        for (int i = 0; i < n_src; i++) begin
          bit ok;
          rx_wrd_valid = 1'b1;
          rx_wrd_data = src[i];
          ok = 1'b0;
          while (!ok) begin
            #2;
            ok = rx_wrd_ready;
            @(negedge clk);
          end
          rx_wrd_valid = 1'b0;
          if ($urandom % 4 == 0) @(negedge clk);
        end
      end
      begin
        for (int j = 0; j < n_exp; j++) begin
          bit got;
          got = 1'b0;
          while (!got) begin
            rx_ent_ready = ($urandom % 3) != 0;
            #2;
            if (rx_ent_valid && rx_ent_ready) begin
              chk(tag, rx_ent_data, expv[j]);
              got = 1'b1;
            end
            @(negedge clk);
          end
        end
        rx_ent_ready = 1'b0;
      end
    join
    repeat (6) @(negedge clk);
    chk({tag, " R10 no extra entry"}, {31'b0, rx_ent_valid}, 32'd0);
  endtask

  task automatic set_cfg(logic [39:0] l, int w);
    cfg_lo = l[19:0];
    cfg_hi = l[39:20];
    wsize_m1 = 5'(w - 1);
  endtask

  task automatic std_pair(int w, int p, bit msb, bit stop_en, string tag);
    int c8;
    c8 = ((w + 7) / 8) * 8;
    set_cfg(layout(w, p, msb, stop_en), w);
    n_src = 3;
    n_exp = 3 * p;
    for (int e = 0; e < 3; e++) begin
      src[e] = $urandom;
      for (int i = 0; i < p; i++) expv[e*p+i] = (src[e] >> (c8 * i)) & wmask(w);
    end
    tx_run({tag, " tx R1 R2 R3 R4 R7"});
    n_src = 3 * p;
    n_exp = 3;
    for (int e = 0; e < 3; e++) begin
      expv[e] = '0;
      for (int i = 0; i < p; i++) begin
        src[e*p+i] = $urandom;
        expv[e] = expv[e] | ((src[e*p+i] & wmask(w)) << (c8 * i));
      end
    end
    rx_run({tag, " rx R8 R9 R10"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R11 tx_wrd_valid in reset", {31'b0, tx_wrd_valid}, 32'd0);
    chk("R11 rx_ent_valid in reset", {31'b0, rx_ent_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R11 tx_ent_ready after reset", {31'b0, tx_ent_ready}, 32'd1);
    chk("R11 tx_wrd_valid after reset", {31'b0, tx_wrd_valid}, 32'd0);
    @(negedge clk);

    for (int w = 1; w <= 32; w++)
      for (int m = 0; m < 2; m++)
        for (int pe = 0; pe < 3; pe++) begin
          int p, c8;
          p = 1 << pe;
          c8 = ((w + 7) / 8) * 8;
          if (c8 * p <= 32) std_pair(w, p, m[0], 1'b1, "sweep");
        end

    // R5: no stop flag anywhere, vector 3 closes the entry
    std_pair(8, 4, 1'b0, 1'b0, "R5 nostop lsb");
    std_pair(7, 4, 1'b1, 1'b0, "R5 nostop msb");

    // R4: garbage vector after the stop vector is ignored
    begin
      logic [39:0] l;
      l = layout(23, 1, 1'b1, 1'b1);
      l[39:30] = {5'd31, 1'b0, 3'd7, 1'b0};
      set_cfg(l, 23);
      n_src = 4; n_exp = 4;
      for (int e = 0; e < 4; e++) begin src[e] = $urandom; expv[e] = src[e] & wmask(23); end
      tx_run("R4 tx vector after stop");
      for (int e = 0; e < 4; e++) begin src[e] = $urandom; expv[e] = src[e] & wmask(23); end
      rx_run("R4 rx vector after stop");
    end

    // R6: 16-bit word built from the low byte of two entries
    begin
      logic [39:0] l;
      l = '0;
      l[9:0] = {5'd0, 1'b0, 3'd7, 1'b1};
      set_cfg(l, 16);
      n_src = 6; n_exp = 3;
      for (int e = 0; e < 6; e++) src[e] = $urandom;
      for (int k = 0; k < 3; k++) expv[k] = {16'b0, src[2*k+1][7:0], src[2*k][7:0]};
      tx_run("R6 tx word spans entries");
      n_src = 3; n_exp = 6;
      for (int k = 0; k < 3; k++) begin
        src[k] = $urandom;
        expv[2*k]   = {24'b0, src[k][7:0]};
        expv[2*k+1] = {24'b0, src[k][15:8]};
      end
      rx_run("R6 rx word spans entries");
    end

    // R2: descending chunk wrapping past bit 0
    begin
      logic [39:0] l;
      l = '0;
      l[9:0] = {5'd2, 1'b1, 3'd7, 1'b1};
      set_cfg(l, 8);
      n_src = 4; n_exp = 4;
      for (int e = 0; e < 4; e++) begin
        src[e] = $urandom;
        expv[e] = {24'b0, src[e][2:0], src[e][31:27]};
      end
      tx_run("R2 tx wrap");
      for (int e = 0; e < 4; e++) begin
        src[e] = $urandom;
        expv[e] = ({24'b0, src[e][7:0]} << 27) | ({24'b0, src[e][7:0]} >> 5);
      end
      rx_run("R2 rx wrap");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule